// File: doc/BRIEF.md
# Read-Sequence Command Detector

This block sits beside a memory port and watches each access as it goes by. An access is one cycle with the strobe high, carrying a 16-bit address and a write level. The block looks for a fixed unlock run of five reads. That run must be followed at once by a sixth read whose address selects one of four commands: store to nonvolatile, recall from nonvolatile, turn automatic store off, or turn automatic store on. When a full run is seen, the matching command output pulses for one clock. A separate level shows that a run is partly matched.

The access stream is observed, not consumed. The block never stalls it, so there is no ready signal and no back-pressure. Every strobed access is taken in the cycle it appears, and an access the block cannot use is simply dropped by the matcher. While the busy input is high, the device behind the port is doing a nonvolatile operation. During that time the block ignores accesses and returns to idle.

Top module: `seqcmd_detect`

## Requirements
- R1: After reset, a read is a matching step when its masked address equals the next entry of the unlock run 0x4E38, 0xB1C7, 0x83E0, 0x7C1F, 0x703F, taken in that order. `seq_active` is high from the cycle after the first matching read until the run ends or aborts.
- R2: A sixth read at 0x8FC0, following five matching reads, pulses `cmd_store`.
- R3: A sixth read at 0x4C63, following five matching reads, pulses `cmd_recall`.
- R4: A sixth read at 0x8B45, following five matching reads, pulses `cmd_auto_off`.
- R5: A sixth read at 0x4B46, following five matching reads, pulses `cmd_auto_on`.
- R6: A read that does not match the next step aborts the run. It is then tested as a first step: a read at 0x4E38 leaves `seq_active` high and the run continues at step two.
- R7: A strobed access with `acc_wr` high aborts the run at any step. No command follows, and the next cycle `seq_active` is low.
- R8: Only address bits 14 down to 2 are compared. Bits 15, 1 and 0 have no effect on matching.
- R9: A command pulse is high for exactly one clock, in the cycle after the edge that samples the sixth read. At most one command output is high at a time. Cycles with `acc_valid` low change nothing.
- R10: While `busy` is high, strobed accesses are ignored, no command is issued, and the run returns to idle.
- R11: A sixth read whose masked address matches none of the four command addresses ends the run with no command, and `seq_active` goes low.
- R12: During and after reset, all four command outputs and `seq_active` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy | input | 1 | Nonvolatile operation in progress; accesses ignored |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_addr | input | 16 | Access address |
| acc_wr | input | 1 | High for a write access, low for a read |
| cmd_store | output | 1 | One-cycle pulse: store to nonvolatile |
| cmd_recall | output | 1 | One-cycle pulse: recall from nonvolatile |
| cmd_auto_off | output | 1 | One-cycle pulse: disable automatic store |
| cmd_auto_on | output | 1 | One-cycle pulse: enable automatic store |
| seq_active | output | 1 | Unlock run partly matched |

## Verification
The only internal state is the step count, and `seq_active` exposes whether it is zero one cycle after every access. A wrong step value shows up by the sixth access of the next run at the latest: a command is either missing or spurious, or it lands on the wrong output. The bench flips every address bit, one at a time, at every position of every command run. Bits outside 14:2 must leave the command unchanged, and bits inside it must abort the run or redirect the command. It also places writes, busy cycles, restarts and idle gaps at each step, so that a step counter that skips, sticks or fails to clear is caught at the ports.

// File: rtl/seqcmd_pkg.sv
package seqcmd_pkg;
  localparam int ADDR_W = 16;
  localparam int PRE_N  = 5;
  localparam int CMD_N  = 4;
  localparam int STEP_W = $clog2(PRE_N + 1);
  localparam logic [ADDR_W-1:0] CMP_MASK = 16'h7FFC;
  // index 0 is the first read of the unlock run
  localparam logic [PRE_N-1:0][ADDR_W-1:0] PRE_ADDR =
    {16'h703F, 16'h7C1F, 16'h83E0, 16'hB1C7, 16'h4E38};
  // index: 0 store, 1 recall, 2 auto off, 3 auto on
  localparam logic [CMD_N-1:0][ADDR_W-1:0] CMD_ADDR =
    {16'h4B46, 16'h8B45, 16'h4C63, 16'h8FC0};
  typedef logic [STEP_W-1:0] step_t;
  typedef logic [CMD_N-1:0]  cmd_vec_t;
endpackage

// File: rtl/seqcmd_addr_decode.sv
module seqcmd_addr_decode
  import seqcmd_pkg::*;
#(
  parameter logic [ADDR_W-1:0] MASK = CMP_MASK
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [PRE_N-1:0]  pre_hit,
  output cmd_vec_t          cmd_hit
);
  logic [ADDR_W-1:0] addr_m;
  assign addr_m = addr & MASK;

  for (genvar i = 0; i < PRE_N; i++) begin : g_pre
    assign pre_hit[i] = (addr_m == (PRE_ADDR[i] & MASK));
  end

  for (genvar j = 0; j < CMD_N; j++) begin : g_cmd
    assign cmd_hit[j] = (addr_m == (CMD_ADDR[j] & MASK));
  end
endmodule

// File: rtl/seqcmd_tracker.sv
module seqcmd_tracker
  import seqcmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic             acc_valid,
  input  logic             acc_wr,
  input  logic [PRE_N-1:0] pre_hit,
  input  cmd_vec_t         cmd_hit,
  output cmd_vec_t         fire_d,
  output logic             active
);
  localparam int EXT_W = 1 << STEP_W;
  localparam step_t LAST = step_t'(PRE_N);

  step_t            step_q, step_d;
  logic [EXT_W-1:0] pre_ext;
  logic             pre_cur, rd_ok;

  assign pre_ext = {{(EXT_W-PRE_N){1'b0}}, pre_hit};
  assign pre_cur = pre_ext[step_q];
  assign rd_ok   = acc_valid && !acc_wr && !busy;

  always_comb begin
    step_d = step_q;
    if (busy) begin
      step_d = '0;
    end else if (acc_valid) begin
      if (acc_wr)                             step_d = '0;
      else if (step_q != LAST && pre_cur)     step_d = step_q + step_t'(1);
      else if (pre_hit[0])                    step_d = step_t'(1);
      else                                    step_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= '0;
    else        step_q <= step_d;
  end

  assign fire_d = (rd_ok && step_q == LAST) ? cmd_hit : '0;
  assign active = (step_q != '0);
endmodule

// File: rtl/seqcmd_pulse.sv
module seqcmd_pulse
  import seqcmd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  cmd_vec_t fire_d,
  output cmd_vec_t fire_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fire_q <= '0;
    else        fire_q <= fire_d;
  end
endmodule

// File: rtl/seqcmd_detect.sv
module seqcmd_detect
  import seqcmd_pkg::*;
#(
  parameter logic [ADDR_W-1:0] MASK = CMP_MASK
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_wr,
  output logic              cmd_store,
  output logic              cmd_recall,
  output logic              cmd_auto_off,
  output logic              cmd_auto_on,
  output logic              seq_active
);
  logic [PRE_N-1:0] pre_hit;
  cmd_vec_t         cmd_hit, fire_d, fire_q;

  seqcmd_addr_decode #(.MASK(MASK)) u_dec (
    .addr(acc_addr), .pre_hit(pre_hit), .cmd_hit(cmd_hit)
  );

  seqcmd_tracker u_trk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .acc_valid(acc_valid),
    .acc_wr(acc_wr), .pre_hit(pre_hit), .cmd_hit(cmd_hit),
    .fire_d(fire_d), .active(seq_active)
  );

  seqcmd_pulse u_pls (
    .clk(clk), .rst_n(rst_n), .fire_d(fire_d), .fire_q(fire_q)
  );

  assign cmd_store    = fire_q[0];
  assign cmd_recall   = fire_q[1];
  assign cmd_auto_off = fire_q[2];
  assign cmd_auto_on  = fire_q[3];
endmodule

// File: rtl/seqcmd_detect_chk.sv
module seqcmd_detect_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        acc_valid,
  input logic [15:0] acc_addr,
  input logic        acc_wr,
  input logic        cmd_store,
  input logic        cmd_recall,
  input logic        cmd_auto_off,
  input logic        cmd_auto_on,
  input logic        seq_active
);
  logic [3:0] cmds;
  logic       cmd_any;
  assign cmds    = {cmd_auto_on, cmd_auto_off, cmd_recall, cmd_store};
  assign cmd_any = |cmds;

  AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmds)); // R9
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_any |=> !cmd_any); // R9
  AST_CMD_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_any |-> $past(seq_active && acc_valid && !acc_wr && !busy)); // R1
  AST_BUSY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!seq_active && !cmd_any)); // R10
  AST_WRITE_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_wr) |=> (!seq_active && !cmd_any)); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_valid && !busy) |=> ($stable(seq_active) && !cmd_any)); // R9

  always_comb begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!cmd_any && !seq_active); // R12
    end
  end

  logic unused_addr;
  assign unused_addr = ^acc_addr;
endmodule

bind seqcmd_detect seqcmd_detect_chk u_chk (.*);

// File: tb/sim_seqcmd_detect.sv
module sim_seqcmd_detect;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        busy = 1'b0;
  logic        acc_valid = 1'b0;
  logic [15:0] acc_addr = '0;
  logic        acc_wr = 1'b0;
  logic        cmd_store, cmd_recall, cmd_auto_off, cmd_auto_on, seq_active;

  int n_chk = 0;
  int n_bad = 0;
  logic [3:0] s_cmd;
  logic       s_act;

  localparam logic [15:0] MSK = 16'h7FFC;
  logic [15:0] pre [5] = '{16'h4E38, 16'hB1C7, 16'h83E0, 16'h7C1F, 16'h703F};
  logic [15:0] cmdad [4] = '{16'h8FC0, 16'h4C63, 16'h8B45, 16'h4B46};

  always #10 clk = ~clk;

  seqcmd_detect u0 (.*);

  function automatic string ctag(int c);
    case (c)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic logic [3:0] cmd_of(logic [15:0] a);
    logic [3:0] r = '0;
    for (int k = 0; k < 4; k++)
      if ((a & MSK) == (cmdad[k] & MSK)) r[k] = 1'b1;
    return r;
  endfunction

  task automatic check(bit ok, string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  // one strobed access; outputs sampled mid-cycle after the sampling edge
  task automatic access(logic [15:0] a, logic w, logic b);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_wr = w; busy = b;
    @(posedge clk); #5;
    s_cmd = {cmd_auto_on, cmd_auto_off, cmd_recall, cmd_store};
    s_act = seq_active;
    @(negedge clk);
    acc_valid = 1'b0; acc_wr = 1'b0; busy = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    #35;
    check({cmd_auto_on, cmd_auto_off, cmd_recall, cmd_store, seq_active} == 5'b0,
          "R12 reset", 8'(seq_active), 8'h0);
    rst_n = 1'b1;
    idle(2);
    check({cmd_auto_on, cmd_auto_off, cmd_recall, cmd_store, seq_active} == 5'b0,
          "R12 after reset", 8'(seq_active), 8'h0);

    // clean runs: step tracking and each command
    for (int c = 0; c < 4; c++) begin
      for (int s = 0; s < 5; s++) begin
        access(pre[s], 1'b0, 1'b0);
        check(s_act && s_cmd == 0, "R1 step", {3'b0, s_act, s_cmd}, 8'h10);
      end
      access(cmdad[c], 1'b0, 1'b0);
      check(s_cmd == 4'(1 << c), ctag(c), 8'(s_cmd), 8'(1 << c));
      check(!s_act, "R11 end of run", 8'(s_act), 8'h0);
      @(posedge clk); #5;
      check({cmd_auto_on, cmd_auto_off, cmd_recall, cmd_store} == 0, "R9 one cycle",
            8'({cmd_auto_on, cmd_auto_off, cmd_recall, cmd_store}), 8'h0);
    end

    // single-bit address flips at every step of every command
    for (int c = 0; c < 4; c++)
      for (int s = 0; s < 6; s++)
        for (int b = 0; b < 16; b++) begin
          logic [15:0] seq [6];
          logic ok;
          logic [3:0] exp;
          for (int k = 0; k < 5; k++) seq[k] = pre[k];
          seq[5] = cmdad[c];
          seq[s] = seq[s] ^ (16'h1 << b);
          ok = 1'b1;
          for (int k = 0; k < 5; k++) if ((seq[k] & MSK) != (pre[k] & MSK)) ok = 1'b0;
          exp = ok ? cmd_of(seq[5]) : 4'h0;
          for (int k = 0; k < 6; k++) access(seq[k], 1'b0, 1'b0);
          check(s_cmd == exp, (b >= 2 && b <= 14) ? "R8 compared bit" : "R8 ignored bit",
                8'(s_cmd), 8'(exp));
        end

    // write at each step aborts
    for (int c = 0; c < 4; c++)
      for (int s = 0; s < 6; s++) begin
        logic got = 1'b0;
        for (int k = 0; k < 6; k++) begin
          access(k < 5 ? pre[k] : cmdad[c], k == s, 1'b0);
          if (s_cmd != 0) got = 1'b1;
          if (k == s) check(!s_act, "R7 write drops run", 8'(s_act), 8'h0);
        end
        check(!got, "R7 no command", 8'(got), 8'h0);
      end

    // restart on first-step address after a mismatch
    access(pre[0], 1'b0, 1'b0);
    access(pre[1], 1'b0, 1'b0);
    access(pre[0], 1'b0, 1'b0);
    check(s_act, "R6 restart keeps run", 8'(s_act), 8'h1);
    for (int k = 1; k < 5; k++) access(pre[k], 1'b0, 1'b0);
    access(cmdad[1], 1'b0, 1'b0);
    check(s_cmd == 4'b0010, "R6 restarted run fires", 8'(s_cmd), 8'h2);
    access(pre[0], 1'b0, 1'b0);
    access(16'h0000, 1'b0, 1'b0);
    check(!s_act, "R6 mismatch aborts", 8'(s_act), 8'h0);

    // unknown sixth address
    for (int k = 0; k < 5; k++) access(pre[k], 1'b0, 1'b0);
    access(16'h1234, 1'b0, 1'b0);
    check(s_cmd == 0 && !s_act, "R11 unknown command", {3'b0, s_act, s_cmd}, 8'h0);

    // busy at each step
    for (int s = 0; s < 6; s++) begin
      logic got = 1'b0;
      for (int k = 0; k < 6; k++) begin
        access(k < 5 ? pre[k] : cmdad[0], 1'b0, k == s);
        if (s_cmd != 0) got = 1'b1;
        if (k == s) check(!s_act, "R10 busy clears", 8'(s_act), 8'h0);
      end
      check(!got, "R10 busy no command", 8'(got), 8'h0);
    end
    for (int k = 0; k < 3; k++) access(pre[k], 1'b0, 1'b0);
    @(negedge clk); busy = 1'b1;
    @(negedge clk); busy = 1'b0; #1;
    check(!seq_active, "R10 busy alone clears", 8'(seq_active), 8'h0);

    // idle gaps between accesses
    for (int k = 0; k < 5; k++) begin
      access(pre[k], 1'b0, 1'b0);
      idle(3);
      #1 check(seq_active, "R9 idle holds", 8'(seq_active), 8'h1);
    end
    access(cmdad[3], 1'b0, 1'b0);
    check(s_cmd == 4'b1000, "R9 gapped run fires", 8'(s_cmd), 8'h8);

    summary();
    $finish;
  end
endmodule